// File: doc/BRIEF.md
# Hobby Servo Position PWM Generator

This block drives the control line of a hobby servo from a 50 MHz clock. It repeats a fixed frame of `FRAME_CYCLES` clock cycles, 1,000,000 by default, which gives 20 ms or 50 Hz. At the start of each frame the control line goes high for a number of cycles set by the commanded angle, then stays low until the frame ends. A one-cycle marker at each frame start lets a controller pace its updates for the pan and tilt axes.

An unsigned position code is mapped linearly into a window of pulse widths. The window lies between the counter-clockwise limit and the clockwise limit, both given in clock cycles. The limits are inputs, so one instance can serve servos with different calibrations. One example is 4.2 % / 7.0 % / 9.8 % of the frame. Another is 3.2 % / 5.6 % / 9.8 %. The mapping is computed by a shift-and-subtract accumulator. The new width waits in a shadow register and is copied into the active compare register only at a frame boundary, so no pulse is ever cut short or stretched. Until the first position has been mapped, the line carries the centre width.

Top module: `servo_pwm_gen`

## Requirements
- R1: A frame lasts exactly `FRAME_CYCLES` cycles. `frame_start` is high only in the first cycle of each frame. The first frame begins in the first cycle after reset is released.
- R2: In every frame, `pwm_out` is high in frame cycles 0 to W-1 and low for the rest of the frame. W is the active width, and there is one pulse per frame.
- R3: After reset, and until a mapped position is ready, W equals `lim_ctr`. The value of `lim_ctr` is taken at reset and at each frame boundary.
- R4: When `pos_load` is high, W becomes `lim_ccw + floor(pos_code * (lim_cw - lim_ccw) / 255)`, with the limits taken in that same cycle. The result is held within [`lim_ccw`, `lim_cw`]. Code 0 gives `lim_ccw` and code 255 gives `lim_cw`.
- R5: If `lim_cw` is not greater than `lim_ccw` when a code is loaded, the mapped W is `lim_ccw`.
- R6: A loaded code leaves the frame in progress unchanged. It takes effect at the first frame boundary at least `POS_W+CNT_W+2` cycles after the load.
- R7: If several codes are loaded within one frame, only the last one sets the next frame's width.
- R8: Changing `lim_ccw` or `lim_cw` without a load has no effect on W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_code | input | POS_W | Commanded position code |
| pos_load | input | 1 | Strobe that captures `pos_code` and the limits |
| lim_ccw | input | CNT_W | Full counter-clockwise pulse width in cycles |
| lim_ctr | input | CNT_W | Centre pulse width used before the first load |
| lim_cw | input | CNT_W | Full clockwise pulse width in cycles |
| pwm_out | output | 1 | Servo control pulse |
| frame_start | output | 1 | One-cycle marker in frame cycle 0 |

## Verification
`frame_start` and `pwm_out` are decoded from the frame counter and the active width register with no extra delay, so the frame-cycle index alone predicts both outputs. The bench counts that index from the first falling edge after reset. At each falling edge it compares `pwm_out` and `frame_start` against that index and the expected width. A load sets its result `POS_W+CNT_W+2` cycles later, so the bench issues every load in the first half of a frame. It expects the old width for the rest of that frame and the new width from the next `frame_start`.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    // Default frame length: 20 ms at 50 MHz
    localparam int DEFAULT_FRAME_CYCLES = 1_000_000;
    localparam int DEFAULT_POS_W        = 8;

    // Mapping accumulator phases
    typedef enum logic [1:0] {
        MAP_IDLE,
        MAP_DIVIDE,
        MAP_COMMIT
    } map_state_e;

    // Span of the calibrated window; zero when the window is empty or inverted
    function automatic logic [31:0] window_span(input logic [31:0] lo, input logic [31:0] hi);
        return (hi > lo) ? (hi - lo) : 32'd0;
    endfunction

endpackage

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
    parameter int FRAME_CYCLES = 1_000_000,
    parameter int CNT_W        = $clog2(FRAME_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             boundary,
    output logic             frame_start
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign frame_cnt   = cnt_q;
    assign boundary    = (cnt_q == LAST);
    assign frame_start = (cnt_q == '0);

endmodule

// File: rtl/servo_pos_mapper.sv
module servo_pos_mapper
    import servo_pwm_pkg::*;
#(
    parameter int POS_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_code,
    input  logic             pos_load,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    output logic [CNT_W-1:0] mapped_w,
    output logic             mapped_valid
);
    localparam int PROD_W = POS_W + CNT_W;
    localparam int STEP_W = $clog2(PROD_W + 1);
    localparam logic [POS_W:0] DIVISOR = {1'b0, {POS_W{1'b1}}};
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PROD_W - 1);

    map_state_e        state_q;
    logic [PROD_W-1:0] quo_q;
    logic [POS_W-1:0]  rem_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  base_q;
    logic [CNT_W-1:0]  top_q;

    logic [CNT_W-1:0]  span;
    logic [PROD_W-1:0] product;
    logic [POS_W:0]    trial;
    logic [POS_W:0]    trial_sub;
    logic              fits;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  clamped;

    assign span    = CNT_W'(window_span(32'(lim_lo), 32'(lim_hi)));
    assign product = PROD_W'(pos_code) * PROD_W'(span);

    // One restoring division step by 2^POS_W-1
    assign trial     = {rem_q, quo_q[PROD_W-1]};
    assign fits      = (trial >= DIVISOR);
    assign trial_sub = fits ? (trial - DIVISOR) : trial;

    // Offset into the window and hold inside it
    assign sum = {1'b0, base_q} + (CNT_W + 1)'(quo_q);
    always_comb begin
        if (top_q <= base_q)
            clamped = base_q;
        else if (sum > {1'b0, top_q})
            clamped = top_q;
        else
            clamped = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= MAP_IDLE;
            quo_q        <= '0;
            rem_q        <= '0;
            step_q       <= '0;
            base_q       <= '0;
            top_q        <= '0;
            mapped_w     <= '0;
            mapped_valid <= 1'b0;
        end else if (pos_load) begin
            // A newer code restarts the accumulator
            state_q <= MAP_DIVIDE;
            quo_q   <= product;
            rem_q   <= '0;
            step_q  <= '0;
            base_q  <= lim_lo;
            top_q   <= lim_hi;
        end else begin
            unique case (state_q)
                MAP_DIVIDE: begin
                    quo_q  <= {quo_q[PROD_W-2:0], fits};
                    rem_q  <= trial_sub[POS_W-1:0];
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP)
                        state_q <= MAP_COMMIT;
                end
                MAP_COMMIT: begin
                    mapped_w     <= clamped;
                    mapped_valid <= 1'b1;
                    state_q      <= MAP_IDLE;
                end
                default: state_q <= MAP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/servo_pulse_cmp.sv
module servo_pulse_cmp #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             boundary,
    input  logic [CNT_W-1:0] mapped_w,
    input  logic             mapped_valid,
    input  logic [CNT_W-1:0] centre_w,
    output logic             pwm
);
    logic [CNT_W-1:0] active_q;

    // Active width changes only at the frame boundary
    always_ff @(posedge clk) begin
        if (rst)
            active_q <= centre_w;
        else if (boundary)
            active_q <= mapped_valid ? mapped_w : centre_w;
    end

    assign pwm = (frame_cnt < active_q);

endmodule

// File: rtl/servo_pwm_gen.sv
module servo_pwm_gen
    import servo_pwm_pkg::*;
#(
    parameter int FRAME_CYCLES = DEFAULT_FRAME_CYCLES,
    parameter int POS_W        = DEFAULT_POS_W,
    parameter int CNT_W        = $clog2(FRAME_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_code,
    input  logic             pos_load,
    input  logic [CNT_W-1:0] lim_ccw,
    input  logic [CNT_W-1:0] lim_ctr,
    input  logic [CNT_W-1:0] lim_cw,
    output logic             pwm_out,
    output logic             frame_start
);
    logic [CNT_W-1:0] frame_cnt;
    logic             boundary;
    logic [CNT_W-1:0] mapped_w;
    logic             mapped_valid;

    servo_frame_timer #(
        .FRAME_CYCLES(FRAME_CYCLES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_cnt  (frame_cnt),
        .boundary   (boundary),
        .frame_start(frame_start)
    );

    servo_pos_mapper #(
        .POS_W(POS_W),
        .CNT_W(CNT_W)
    ) u_mapper (
        .clk         (clk),
        .rst         (rst),
        .pos_code    (pos_code),
        .pos_load    (pos_load),
        .lim_lo      (lim_ccw),
        .lim_hi      (lim_cw),
        .mapped_w    (mapped_w),
        .mapped_valid(mapped_valid)
    );

    servo_pulse_cmp #(
        .CNT_W(CNT_W)
    ) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .frame_cnt   (frame_cnt),
        .boundary    (boundary),
        .mapped_w    (mapped_w),
        .mapped_valid(mapped_valid),
        .centre_w    (lim_ctr),
        .pwm         (pwm_out)
    );

endmodule

// File: rtl/servo_pwm_gen_chk.sv
module servo_pwm_gen_chk #(
    parameter int FRAME_CYCLES = 1_000_000
) (
    input logic clk,
    input logic rst,
    input logic pwm_out,
    input logic frame_start
);
    logic [31:0] gap_q;
    logic        seen_q;

    // Cycles since the last frame marker
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    marker_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R1
    marker_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && seen_q) |-> (gap_q == 32'(FRAME_CYCLES - 1)));

    // R2
    pulse_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> frame_start);

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwm_out && !frame_start) |=> (!pwm_out || frame_start));

endmodule

bind servo_pwm_gen servo_pwm_gen_chk #(
    .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_out    (pwm_out),
    .frame_start(frame_start)
);

// File: tb/tb_servo_pwm_gen.sv
module tb_servo_pwm_gen;
    localparam int FRAME = 2000;
    localparam int POS_W = 8;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam int CTR   = 140;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [POS_W-1:0] pos_code = '0;
    logic             pos_load = 1'b0;
    logic [CNT_W-1:0] lim_ccw = CNT_W'(84);
    logic [CNT_W-1:0] lim_ctr = CNT_W'(CTR);
    logic [CNT_W-1:0] lim_cw  = CNT_W'(196);
    logic             pwm_out;
    logic             frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Scheduled loads for the next frame
    int n_ld;
    int ld_at  [2];
    int ld_pos [2];
    int ld_lo  [2];
    int ld_hi  [2];
    int exp_w;

    always #10 clk = ~clk;

    servo_pwm_gen #(
        .FRAME_CYCLES(FRAME),
        .POS_W       (POS_W)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .pos_code   (pos_code),
        .pos_load   (pos_load),
        .lim_ccw    (lim_ccw),
        .lim_ctr    (lim_ctr),
        .lim_cw     (lim_cw),
        .pwm_out    (pwm_out),
        .frame_start(frame_start)
    );

    function automatic int map_width(input int p, input int lo, input int hi);
        if (hi <= lo) return lo;
        return lo + (p * (hi - lo)) / 255;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Runs one frame from its index-0 falling edge to the next one
    task automatic run_frame(input string tag);
        int high_cnt = 0;
        int fs_cnt   = 0;
        int bad      = 0;
        int last_ld  = -1;
        for (int i = 0; i < FRAME; i++) begin
            if (pwm_out) high_cnt++;
            if (frame_start) fs_cnt++;
            if (pwm_out != (i < exp_w)) bad++;
            if (frame_start != (i == 0)) bad++;
            pos_load = 1'b0;
            for (int k = 0; k < n_ld; k++) begin
                if (i == ld_at[k]) begin
                    pos_load = 1'b1;
                    pos_code = POS_W'(ld_pos[k]);
                    lim_ccw  = CNT_W'(ld_lo[k]);
                    lim_cw   = CNT_W'(ld_hi[k]);
                    last_ld  = k;
                end
            end
            // R8: disturb limits after the last load without a strobe
            if (n_ld > 0 && i == ld_at[n_ld-1] + 200) begin
                lim_ccw = CNT_W'($urandom_range(10, 900));
                lim_cw  = CNT_W'($urandom_range(10, 900));
            end
            @(negedge clk);
        end
        check({"R2 width ", tag}, high_cnt, exp_w);
        check({"R2 shape ", tag}, bad, 0);
        check({"R1 markers ", tag}, fs_cnt, 1);
        if (last_ld >= 0)
            exp_w = map_width(ld_pos[last_ld], ld_lo[last_ld], ld_hi[last_ld]);
        n_ld = 0;
    endtask

    task automatic one_load(input int p, input int lo, input int hi, input int at);
        n_ld = 1;
        ld_at[0] = at; ld_pos[0] = p; ld_lo[0] = lo; ld_hi[0] = hi;
    endtask

    initial begin
        void'($urandom(32'd4242));
        n_ld  = 0;
        exp_w = CTR;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 R3: first cycle after reset is frame cycle 0 with centre pulse
        check("R1 marker after reset", int'(frame_start), 1);
        check("R3 pulse after reset", int'(pwm_out), 1);

        // R3: centre width holds with no load
        run_frame("R3 centre f0");
        run_frame("R3 centre f1");

        // R4 R6: code 0 -> ccw limit; current frame unchanged
        one_load(0, 84, 196, 10);
        run_frame("R6 load frame");
        one_load(255, 84, 196, 700);
        run_frame("R4 code0");
        one_load(128, 84, 196, 5);
        run_frame("R4 code255");
        // R7: two loads in one frame, the later wins
        n_ld = 2;
        ld_at[0] = 10;  ld_pos[0] = 40;  ld_lo[0] = 64; ld_hi[0] = 196;
        ld_at[1] = 300; ld_pos[1] = 200; ld_lo[1] = 64; ld_hi[1] = 196;
        run_frame("R4 code128");
        // R5: inverted and equal limits
        one_load(180, 300, 100, 20);
        run_frame("R7 last wins");
        one_load(99, 150, 150, 20);
        run_frame("R5 inverted");
        run_frame("R5 equal");
        // R8: no load; limits disturbed in previous frames must not matter
        run_frame("R8 hold");

        // Constrained random frames
        for (int f = 0; f < 20; f++) begin
            int lo = $urandom_range(20, 400);
            int hi = lo + $urandom_range(0, 600) - 50;
            if (hi < 0) hi = 0;
            one_load($urandom_range(0, 255), lo, hi, $urandom_range(1, FRAME / 2));
            run_frame("R4 random");
        end
        run_frame("R6 final");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule